// File: doc/BRIEF.md
# Supply Monitor and Reset Sequencer

This block turns three digital supply-comparator flags (supply under the warning level, under the minimum operating level, under the backup-cell level) plus three reset-related pins into the reset and power-state controls of a small processor subsystem. It produces the CPU reset, a one-shot warning interrupt request, a low-active backup-in-use flag, the pull-down enable of a shared open-drain reset line, a bus-inhibit level that parks every memory enable and the write strobe high, and a filtered bootstrap-loader request.

Every asynchronous input crosses two flops before use. A long counted delay holds the CPU in reset after the supply comes back, and any new dip restarts it. The bootstrap pin is filtered so that only a level held for a full window changes the request. A one-cycle start pulse is raised either when the request appears while the CPU runs or when reset lifts while the request is already held. That second case covers a pin strapped low at power-up.

Top module: `pwr_rst_seq`

## Requirements
- R1: While `por_n` is low and in the first cycle after it rises, `cpu_rst`, `bus_inhibit` and `rst_line_drive` are 1, `pf_n` is 0, and `warn_irq`, `boot_req` and `boot_start` are 0.
- R2: Two clock edges after `below_min` goes high, `cpu_rst`, `bus_inhibit` and `rst_line_drive` are 1, and they stay 1 while it stays high.
- R3: After the synchronised `below_min` falls, `cpu_rst` and `bus_inhibit` stay 1 for POR_CYCLES (default 21504) further clock edges. A new rise of `below_min` restarts the whole count.
- R4: A high level on `rst_pin` forces `cpu_rst` to 1 two edges later and does not raise `bus_inhibit`.
- R5: A low level sensed on `rst_line_in` forces `cpu_rst` to 1 two edges later, so that several devices sharing the line reset together.
- R6: `pf_n` is the inverse of `below_batt`, delayed by two edges.
- R7: Each rise of the synchronised `below_warn` raises `warn_irq` for exactly one cycle when the enable is set. It has no effect on `cpu_rst`, and a steady warning level raises no further pulse.
- R8: The warning enable is 0 after reset and is loaded from `warn_en_d` on a clock edge with `warn_en_we` = 1. While the enable is 0, a warning raises no request.
- R9: `boot_req` rises after `boot_pin_n` (active low) has been sampled low for BOOT_FILT (default 48) consecutive synchronised cycles. It falls after the same count of high samples. Shorter excursions leave it unchanged.
- R10: `boot_start` pulses for one cycle when `boot_req` rises while `cpu_rst` is 0, or when `cpu_rst` falls while `boot_req` is 1, including at the end of the power-up delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous low-active chip power-on reset |
| below_warn | input | 1 | Comparator flag: supply under warning level |
| below_min | input | 1 | Comparator flag: supply under minimum operating level |
| below_batt | input | 1 | Comparator flag: supply under backup cell level |
| rst_pin | input | 1 | External high-active reset input |
| rst_line_in | input | 1 | Sensed level of the shared open-drain reset line |
| boot_pin_n | input | 1 | Low-active bootstrap request pin |
| warn_en_we | input | 1 | Write strobe for the warning enable |
| warn_en_d | input | 1 | New warning enable value |
| cpu_rst | output | 1 | CPU reset, high active |
| warn_irq | output | 1 | One-cycle warning interrupt request |
| pf_n | output | 1 | Low while the backup source is in use |
| rst_line_drive | output | 1 | 1 pulls the shared reset line low |
| bus_inhibit | output | 1 | 1 forces all memory enables and write strobe inactive |
| boot_req | output | 1 | Filtered bootstrap request level |
| boot_start | output | 1 | One-cycle bootstrap-entry pulse |

## Verification
On every cycle the assertions check that the line pull-down and the supply reset only occur together with bus inhibit, that inhibit always implies CPU reset, and that a forced reset from either pin is reflected at once. They also check that interrupt and boot-start pulses last one cycle, that no interrupt leaves while the enable is clear, and that a boot start only occurs with a held request. The exact length of the power-up delay, the restart of that delay on a new dip, and the rejection of short bootstrap glitches cannot be seen from any single cycle. The same holds for the start pulse at the end of a power-up with the pin strapped low. Only the bench's reference model, compared every clock across whole scenarios, shows these.

// File: rtl/prs_pkg.sv
package prs_pkg;
   typedef struct packed {
      logic warn;
      logic min;
      logic batt;
      logic ext_rst;
      logic line;
      logic boot_n;
   } prs_in_t;

   localparam int IN_W = $bits(prs_in_t);

   // Values assumed while the chip reset is held: supply low, pins idle.
   localparam prs_in_t IN_IDLE = '{warn: 1'b1, min: 1'b1, batt: 1'b1,
                                   ext_rst: 1'b0, line: 1'b1, boot_n: 1'b1};
endpackage

// File: rtl/prs_sync.sv
module prs_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] IDLE = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("prs_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[i] <= IDLE;
            else        stg[i] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[i] <= IDLE;
            else        stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/prs_por_timer.sv
module prs_por_timer #(
   parameter int CYCLES = 21504
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   output logic done
);
   if (CYCLES < 1) begin : g_bad_cycles
      $error("prs_por_timer: CYCLES must be positive");
   end

   localparam int CW = $clog2(CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(CYCLES);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)           cnt <= '0;
      else if (hold)        cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;

   assign done = (cnt == LAST);
endmodule

// File: rtl/prs_boot_filter.sv
module prs_boot_filter #(
   parameter int FILT = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_low,
   output logic req
);
   if (FILT < 2) begin : g_bad_filt
      $error("prs_boot_filter: FILT must be at least 2");
   end

   localparam int FW = $clog2(FILT);
   localparam logic [FW-1:0] LAST = FW'(FILT - 1);

   logic [FW-1:0] run;
   logic          differ;

   assign differ = (level_low != req);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         run <= '0;
         req <= 1'b0;
      end else if (!differ) begin
         run <= '0;
      end else if (run == LAST) begin
         run <= '0;
         req <= ~req;
      end else begin
         run <= run + 1'b1;
      end
endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq #(
   parameter int SYNC_STAGES = 2,
   parameter int POR_CYCLES  = 21504,
   parameter int BOOT_FILT   = 48
) (
   input  logic clk,
   input  logic por_n,
   input  logic below_warn,
   input  logic below_min,
   input  logic below_batt,
   input  logic rst_pin,
   input  logic rst_line_in,
   input  logic boot_pin_n,
   input  logic warn_en_we,
   input  logic warn_en_d,
   output logic cpu_rst,
   output logic warn_irq,
   output logic pf_n,
   output logic rst_line_drive,
   output logic bus_inhibit,
   output logic boot_req,
   output logic boot_start
);
   import prs_pkg::*;

   prs_in_t raw_in, syn;
   logic    por_done;
   logic    warn_en_q, warn_prev, rst_prev, req_prev;

   assign raw_in = '{warn: below_warn, min: below_min, batt: below_batt,
                     ext_rst: rst_pin, line: rst_line_in, boot_n: boot_pin_n};

   prs_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .IDLE(IN_IDLE)) u_sync (
      .clk(clk), .rst_n(por_n), .d(raw_in), .q(syn)
   );

   prs_por_timer #(.CYCLES(POR_CYCLES)) u_por (
      .clk(clk), .rst_n(por_n), .hold(syn.min), .done(por_done)
   );

   prs_boot_filter #(.FILT(BOOT_FILT)) u_boot (
      .clk(clk), .rst_n(por_n), .level_low(~syn.boot_n), .req(boot_req)
   );

   assign rst_line_drive = syn.min;
   assign bus_inhibit    = syn.min | ~por_done;
   assign cpu_rst        = bus_inhibit | syn.ext_rst | ~syn.line;
   assign pf_n           = ~syn.batt;

   always_ff @(posedge clk or negedge por_n)
      if (!por_n) begin
         warn_en_q  <= 1'b0;
         warn_prev  <= 1'b1;
         rst_prev   <= 1'b1;
         req_prev   <= 1'b0;
         warn_irq   <= 1'b0;
         boot_start <= 1'b0;
      end else begin
         if (warn_en_we) warn_en_q <= warn_en_d;
         warn_prev  <= syn.warn;
         rst_prev   <= cpu_rst;
         req_prev   <= boot_req;
         warn_irq   <= syn.warn & ~warn_prev & warn_en_q;
         boot_start <= (boot_req & ~req_prev & ~cpu_rst)
                     | (boot_req & rst_prev & ~cpu_rst);
      end
endmodule

// File: rtl/pwr_rst_seq_chk.sv
module pwr_rst_seq_chk (
   input logic clk,
   input logic por_n,
   input logic cpu_rst,
   input logic bus_inhibit,
   input logic rst_line_drive,
   input logic warn_irq,
   input logic boot_req,
   input logic boot_start,
   input logic en_q,
   input logic ext_rst_s,
   input logic line_s
);
   p_drive_inhibit_r2: assert property (@(posedge clk) disable iff (!por_n)
      rst_line_drive |-> bus_inhibit);
   p_inhibit_rst_r3: assert property (@(posedge clk) disable iff (!por_n)
      bus_inhibit |-> cpu_rst);
   p_ext_rst_r4: assert property (@(posedge clk) disable iff (!por_n)
      ext_rst_s |-> cpu_rst);
   p_line_rst_r5: assert property (@(posedge clk) disable iff (!por_n)
      !line_s |-> cpu_rst);
   p_irq_once_r7: assert property (@(posedge clk) disable iff (!por_n)
      warn_irq |=> !warn_irq);
   p_irq_enabled_r8: assert property (@(posedge clk) disable iff (!por_n)
      warn_irq |-> $past(en_q));
   p_start_once_r10: assert property (@(posedge clk) disable iff (!por_n)
      boot_start |=> !boot_start);
   p_start_held_r10: assert property (@(posedge clk) disable iff (!por_n)
      boot_start |-> (boot_req && !cpu_rst));
endmodule

bind pwr_rst_seq pwr_rst_seq_chk u_chk (
   .clk(clk), .por_n(por_n), .cpu_rst(cpu_rst), .bus_inhibit(bus_inhibit),
   .rst_line_drive(rst_line_drive), .warn_irq(warn_irq), .boot_req(boot_req),
   .boot_start(boot_start), .en_q(warn_en_q), .ext_rst_s(syn.ext_rst),
   .line_s(syn.line)
);

// File: tb/sim_pwr_rst_seq.sv
`timescale 1ns/1ps
module sim_pwr_rst_seq;
   localparam int POR = 21504;
   localparam int FILT = 48;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic below_warn = 1'b1, below_min = 1'b1, below_batt = 1'b1;
   logic rst_pin = 1'b0, rst_line_in = 1'b1, boot_pin_n = 1'b1;
   logic warn_en_we = 1'b0, warn_en_d = 1'b0;
   logic cpu_rst, warn_irq, pf_n, rst_line_drive, bus_inhibit, boot_req, boot_start;

   int checks = 0, failures = 0;
   int irq_seen = 0, start_seen = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   pwr_rst_seq u0 (
      .clk(clk), .por_n(por_n), .below_warn(below_warn), .below_min(below_min),
      .below_batt(below_batt), .rst_pin(rst_pin), .rst_line_in(rst_line_in),
      .boot_pin_n(boot_pin_n), .warn_en_we(warn_en_we), .warn_en_d(warn_en_d),
      .cpu_rst(cpu_rst), .warn_irq(warn_irq), .pf_n(pf_n),
      .rst_line_drive(rst_line_drive), .bus_inhibit(bus_inhibit),
      .boot_req(boot_req), .boot_start(boot_start)
   );

   // Behavioural reference model
   bit qw[$], qm[$], qb[$], qr[$], ql[$], qp[$];
   int  m_cnt, m_run;
   bit  m_en, m_wprev, m_rprev, m_qprev, m_irq, m_start, m_req;

   task automatic model_reset();
      qw = '{1, 1}; qm = '{1, 1}; qb = '{1, 1};
      qr = '{0, 0}; ql = '{1, 1}; qp = '{1, 1};
      m_cnt = 0; m_run = 0; m_en = 0; m_wprev = 1; m_rprev = 1;
      m_qprev = 0; m_irq = 0; m_start = 0; m_req = 0;
   endtask

   function automatic bit m_inhibit();
      return qm[0] || (m_cnt < POR);
   endfunction
   function automatic bit m_rst();
      return m_inhibit() || qr[0] || !ql[0];
   endfunction

   initial model_reset();

   always @(posedge clk or negedge por_n) begin
      if (!por_n) model_reset();
      else begin
         bit rst_now, w_now, low_now;
         rst_now = m_rst();
         w_now = qw[0];
         low_now = !qp[0];
         m_irq = w_now && !m_wprev && m_en;
         m_start = m_req && !rst_now && (!m_qprev || m_rprev);
         m_wprev = w_now;
         m_rprev = rst_now;
         m_qprev = m_req;
         if (warn_en_we) m_en = warn_en_d;
         if (qm[0]) m_cnt = 0; else if (m_cnt < POR) m_cnt++;
         if (low_now != m_req) begin
            if (m_run == FILT - 1) begin m_run = 0; m_req = !m_req; end
            else m_run++;
         end else m_run = 0;
         qw = '{qw[1], below_warn}; qm = '{qm[1], below_min};
         qb = '{qb[1], below_batt}; qr = '{qr[1], rst_pin};
         ql = '{ql[1], rst_line_in}; qp = '{qp[1], boot_pin_n};
      end
   end

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Per-cycle comparison, away from the active edge
   always @(negedge clk) if (por_n && !finished) begin
      check("R3", "cpu_rst", cpu_rst, m_rst());
      check("R2", "bus_inhibit", bus_inhibit, m_inhibit());
      check("R2", "rst_line_drive", rst_line_drive, qm[0]);
      check("R6", "pf_n", pf_n, !qb[0]);
      check("R7", "warn_irq", warn_irq, m_irq);
      check("R9", "boot_req", boot_req, m_req);
      check("R10", "boot_start", boot_start, m_start);
      if (warn_irq) irq_seen++;
      if (boot_start) start_seen++;
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
   end

   initial begin
      int base;
      cyc(3);
      por_n = 1'b1;
      cyc(1);
      // R1 reset state
      check("R1", "cpu_rst", cpu_rst, 1); check("R1", "bus_inhibit", bus_inhibit, 1);
      check("R1", "rst_line_drive", rst_line_drive, 1); check("R1", "pf_n", pf_n, 0);
      check("R1", "warn_irq", warn_irq, 0); check("R1", "boot_req", boot_req, 0);
      check("R1", "boot_start", boot_start, 0);

      // R3 power-up delay
      below_batt = 0; below_min = 0; below_warn = 0;
      cyc(POR - 300);
      check("R3", "cpu_rst early", cpu_rst, 1);
      cyc(400);
      check("R3", "cpu_rst released", cpu_rst, 0);
      check("R6", "pf_n supply good", pf_n, 1);

      // R8 enable starts at 0: warning ignored
      base = irq_seen;
      below_warn = 1; cyc(10);
      check("R8", "irq while disabled", irq_seen - base, 0);
      below_warn = 0; cyc(5);
      warn_en_we = 1; warn_en_d = 1; cyc(1); warn_en_we = 0;
      // R7 single pulse per event
      below_warn = 1; cyc(10);
      check("R7", "irq pulses", irq_seen - base, 1);
      cyc(30);
      check("R7", "irq pulses steady", irq_seen - base, 1);
      check("R7", "cpu_rst unaffected", cpu_rst, 0);
      below_warn = 0; cyc(5);

      // R4 external reset
      rst_pin = 1; cyc(3);
      check("R4", "cpu_rst", cpu_rst, 1); check("R4", "bus_inhibit", bus_inhibit, 0);
      rst_pin = 0; cyc(3);
      check("R4", "cpu_rst released", cpu_rst, 0);

      // R5 shared line pulled low
      rst_line_in = 0; cyc(3);
      check("R5", "cpu_rst", cpu_rst, 1);
      rst_line_in = 1; cyc(3);
      check("R5", "cpu_rst released", cpu_rst, 0);

      // R9 glitch rejected, then full request
      base = start_seen;
      boot_pin_n = 0; cyc(20); boot_pin_n = 1; cyc(60);
      check("R9", "glitch boot_req", boot_req, 0);
      boot_pin_n = 0; cyc(40);
      check("R9", "boot_req early", boot_req, 0);
      cyc(20);
      check("R9", "boot_req set", boot_req, 1);
      check("R10", "start pulses", start_seen - base, 1);
      boot_pin_n = 1; cyc(40);
      check("R9", "boot_req held", boot_req, 1);
      cyc(20);
      check("R9", "boot_req cleared", boot_req, 0);

      // R2 brownout and R3 restart
      below_warn = 1; below_min = 1; cyc(3);
      check("R2", "cpu_rst", cpu_rst, 1); check("R2", "bus_inhibit", bus_inhibit, 1);
      check("R2", "rst_line_drive", rst_line_drive, 1);
      below_batt = 1; cyc(3);
      check("R6", "pf_n backup", pf_n, 0);
      below_batt = 0; below_min = 0; cyc(1000);
      below_min = 1; cyc(5); below_min = 0; below_warn = 0;
      cyc(POR - 200);
      check("R3", "restarted delay", cpu_rst, 1);
      cyc(300);
      check("R3", "released after restart", cpu_rst, 0);

      // R10 bootstrap strapped at power-up
      por_n = 0; below_min = 1; below_batt = 1; below_warn = 1; boot_pin_n = 0;
      cyc(3); por_n = 1;
      base = start_seen;
      cyc(2); below_min = 0; below_batt = 0; below_warn = 0;
      cyc(POR - 100);
      check("R10", "no start during reset", start_seen - base, 0);
      check("R9", "req held in reset", boot_req, 1);
      cyc(200);
      check("R10", "start at release", start_seen - base, 1);
      cyc(5);
      summary();
   end
endmodule